// File: doc/BRIEF.md
# Thread-Aware DRAM Request Priority Selector

This block picks the next DRAM request to issue from a shared queue that holds requests from 16 threads. Every cycle it looks at all valid queue entries together with per-thread scheduling hints and names exactly one winner. If no entry is valid, it names none. The hints come from outside the block:
- a flag marking threads that are holding up the rest of the program,
- a latency-versus-bandwidth class,
- a memory-intensity figure,
- a shuffled rank.

The block also tracks loop progress for each thread. It counts the loop-branch events of each thread and clears all counts at a barrier. At each interval boundary it takes a snapshot of the counts. Threads that lag behind in that snapshot are favoured until the next boundary. The grant output is combinational from the queue contents, the hints and the held snapshot, so a memory controller can use it in the same cycle.

Top module: `thrd_req_arbiter`

## Requirements
- R1: `grantValid` is 1 exactly when at least one `reqValid` bit is set. When it is 1, `grantIdx` names a valid entry. An empty queue gives `grantValid` = 0.
- R2: A valid entry with its row-hit flag set is always granted ahead of any valid entry without that flag.
- R3: Among entries with equal row-hit flags, an entry whose thread has its `thrLimiter` bit set wins over an entry whose thread has it clear.
- R4: Among limiter threads, a latency-sensitive thread (`thrLatency` = 1) wins over a bandwidth-sensitive one. Between two latency-sensitive threads, the smaller `thrIntensity` value wins.
- R5: Between two bandwidth-sensitive limiter threads, the larger `thrRank` value wins.
- R6: Between non-limiter threads, when loop progress is in force, the thread with the smaller captured iteration count wins. Equal counts are settled by the larger `thrRank`.
- R7: Between non-limiter threads, when loop progress is not in force, the larger `thrRank` alone decides, whatever the iteration counts are.
- R8: Each thread has a 32-bit iteration counter. It adds one in every cycle in which that thread's `loopBranchHit` bit is 1. A `barrier` cycle clears all counters, and the clear wins over an increment in the same cycle.
- R9: At an `intervalEnd` cycle, the block captures the counter values from before that edge, together with the `loopValid` flag. This capture sets whether loop progress is in force. The captured values are held until the next `intervalEnd`, even through barriers and further increments. After reset all captured counts are 0 and loop progress is not in force.
- R10: When all earlier criteria are equal, the larger `reqAge` (older request) wins. If the ages are also equal, the lower queue index wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 128 | Valid bit per queue entry |
| reqThread | input | 512 | 4-bit thread ID per entry, entry i in bits [4i+3:4i] |
| reqRowHit | input | 128 | Entry targets the row that is open in its bank |
| reqAge | input | 1024 | 8-bit age per entry; larger means older |
| thrLimiter | input | 16 | Limiter flag per thread |
| thrLatency | input | 16 | 1 = latency-sensitive, 0 = bandwidth-sensitive |
| thrIntensity | input | 128 | 8-bit memory intensity per thread |
| thrRank | input | 64 | 4-bit shuffled rank per thread; larger is preferred |
| loopValid | input | 1 | Loop progress is meaningful; sampled at interval end |
| loopBranchHit | input | 16 | Thread executed the loop branch this cycle |
| barrier | input | 1 | Clear all iteration counters |
| intervalEnd | input | 1 | Capture counts and loop-valid flag for the next interval |
| grantValid | output | 1 | A request is granted this cycle |
| grantIdx | output | 7 | Queue index of the granted request |

## Verification
The grant is purely combinational from the queue and the hint inputs, so a fault in the ordering shows up on `grantIdx` in the same cycle as the pattern that exposes it. Faults in the stored loop state take longer to surface. A counter that misses an increment or a clear, or a snapshot that is taken at the wrong time, stays hidden until an interval boundary with loop progress in force. From then on it causes a wrong choice between non-limiter threads whose counts differ. For this reason the bench runs counting, barrier and capture sequences and then places one request per affected thread in the queue.

// File: rtl/thrd_arb_pkg.sv
package thrd_arb_pkg;
  localparam int NUM_THREADS = 16;
  localparam int THR_W = $clog2(NUM_THREADS);

  // strobes from control to datapath
  typedef struct packed {
    logic [NUM_THREADS-1:0] incr;
    logic clearAll;
    logic capture;
    logic useLoop;
  } arbStrobe_t;
endpackage

// File: rtl/arbCtrl.sv
module arbCtrl
  import thrd_arb_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic loopValid,
  input  logic [NUM_THREADS-1:0] loopBranchHit,
  input  logic barrier,
  input  logic intervalEnd,
  output arbStrobe_t strb
);
  logic useLoopQ;

  always_ff @(posedge clk) begin
    if (!rstN) useLoopQ <= 1'b0;
    else if (intervalEnd) useLoopQ <= loopValid;
  end

  always_comb begin
    strb.incr = loopBranchHit & {NUM_THREADS{~barrier}};
    strb.clearAll = barrier;
    strb.capture = intervalEnd;
    strb.useLoop = useLoopQ;
  end

  // R9
  loop_flag_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !intervalEnd |=> $stable(useLoopQ));
  // R9
  loop_flag_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    intervalEnd |=> (useLoopQ == $past(loopValid)));
endmodule

// File: rtl/arbKeyPath.sv
module arbKeyPath
  import thrd_arb_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int AGE_W = 8,
  parameter int INT_W = 8,
  parameter int RANK_W = 4,
  parameter int CNT_W = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic clk,
  input  logic rstN,
  input  arbStrobe_t strb,
  input  logic [DEPTH-1:0] reqValid,
  input  logic [DEPTH*THR_W-1:0] reqThread,
  input  logic [DEPTH-1:0] reqRowHit,
  input  logic [DEPTH*AGE_W-1:0] reqAge,
  input  logic [NUM_THREADS-1:0] thrLimiter,
  input  logic [NUM_THREADS-1:0] thrLatency,
  input  logic [NUM_THREADS*INT_W-1:0] thrIntensity,
  input  logic [NUM_THREADS*RANK_W-1:0] thrRank,
  output logic grantValid,
  output logic [IDX_W-1:0] grantIdx
);
  localparam int MID_W = CNT_W;
  localparam int THR_KEY_W = 2 + MID_W + RANK_W;
  localparam int KEY_W = 1 + THR_KEY_W + AGE_W;

  logic [CNT_W-1:0] loopCnt [NUM_THREADS];
  logic [CNT_W-1:0] snapCnt [NUM_THREADS];
  logic [THR_KEY_W-1:0] thrKey [NUM_THREADS];
  logic [KEY_W-1:0] entKey [DEPTH];

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    logic isLim, isLat;
    logic [MID_W-1:0] midField;
    assign isLim = thrLimiter[t];
    assign isLat = thrLatency[t];

    always_ff @(posedge clk) begin
      if (!rstN) loopCnt[t] <= '0;
      else if (strb.clearAll) loopCnt[t] <= '0;
      else if (strb.incr[t]) loopCnt[t] <= loopCnt[t] + 1'b1;
    end

    always_ff @(posedge clk) begin
      if (!rstN) snapCnt[t] <= '0;
      else if (strb.capture) snapCnt[t] <= loopCnt[t];
    end

    // smaller intensity or count must give a larger key
    always_comb begin
      if (isLim && isLat)
        midField = {{(MID_W-INT_W){1'b1}}, ~thrIntensity[t*INT_W +: INT_W]};
      else if (!isLim && strb.useLoop)
        midField = ~snapCnt[t];
      else
        midField = '0;
      thrKey[t] = {isLim, isLim & isLat, midField, thrRank[t*RANK_W +: RANK_W]};
    end

    // R8
    cnt_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
      strb.clearAll |=> (loopCnt[t] == '0));
    // R8
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rstN)
      (strb.incr[t] && !strb.clearAll) |=> (loopCnt[t] == $past(loopCnt[t]) + 1'b1));
    // R9
    snap_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      !strb.capture |=> $stable(snapCnt[t]));
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    assign entKey[i] = {reqRowHit[i], thrKey[reqThread[i*THR_W +: THR_W]],
                        reqAge[i*AGE_W +: AGE_W]};
  end

  // linear scan; strict compare keeps the lower index on equal keys
  always_comb begin
    logic [KEY_W-1:0] bestKey;
    bestKey = '0;
    grantValid = 1'b0;
    grantIdx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (reqValid[i] && (!grantValid || entKey[i] > bestKey)) begin
        grantValid = 1'b1;
        grantIdx = IDX_W'(i);
        bestKey = entKey[i];
      end
    end
  end

  logic anyHit, anyLimReq;
  always_comb begin
    anyHit = |(reqValid & reqRowHit);
    anyLimReq = 1'b0;
    for (int i = 0; i < DEPTH; i++)
      if (reqValid[i] && thrLimiter[reqThread[i*THR_W +: THR_W]]) anyLimReq = 1'b1;
  end

  // R1
  grant_live_chk: assert property (@(posedge clk) disable iff (!rstN)
    grantValid == (|reqValid));
  // R1
  grant_valid_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |-> reqValid[grantIdx]);
  // R2
  row_hit_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    anyHit |-> reqRowHit[grantIdx]);
  // R3
  limiter_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!anyHit && anyLimReq) |-> thrLimiter[reqThread[grantIdx*THR_W +: THR_W]]);
endmodule

// File: rtl/thrd_req_arbiter.sv
module thrd_req_arbiter
  import thrd_arb_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int AGE_W = 8,
  parameter int INT_W = 8,
  parameter int RANK_W = 4,
  parameter int CNT_W = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic clk,
  input  logic rstN,
  input  logic [DEPTH-1:0] reqValid,
  input  logic [DEPTH*THR_W-1:0] reqThread,
  input  logic [DEPTH-1:0] reqRowHit,
  input  logic [DEPTH*AGE_W-1:0] reqAge,
  input  logic [NUM_THREADS-1:0] thrLimiter,
  input  logic [NUM_THREADS-1:0] thrLatency,
  input  logic [NUM_THREADS*INT_W-1:0] thrIntensity,
  input  logic [NUM_THREADS*RANK_W-1:0] thrRank,
  input  logic loopValid,
  input  logic [NUM_THREADS-1:0] loopBranchHit,
  input  logic barrier,
  input  logic intervalEnd,
  output logic grantValid,
  output logic [IDX_W-1:0] grantIdx
);
  arbStrobe_t strb;

  arbCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .loopValid(loopValid), .loopBranchHit(loopBranchHit),
    .barrier(barrier), .intervalEnd(intervalEnd), .strb(strb)
  );

  arbKeyPath #(
    .DEPTH(DEPTH), .AGE_W(AGE_W), .INT_W(INT_W), .RANK_W(RANK_W), .CNT_W(CNT_W)
  ) u_path (
    .clk(clk), .rstN(rstN), .strb(strb),
    .reqValid(reqValid), .reqThread(reqThread), .reqRowHit(reqRowHit), .reqAge(reqAge),
    .thrLimiter(thrLimiter), .thrLatency(thrLatency), .thrIntensity(thrIntensity),
    .thrRank(thrRank), .grantValid(grantValid), .grantIdx(grantIdx)
  );
endmodule

// File: tb/thrd_req_arbiter_tb_top.sv
module thrd_req_arbiter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 128;
  localparam int NT = 16;
  localparam int TW = 4;
  localparam int AW = 8;
  localparam int IW = 8;
  localparam int RW = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [DEPTH-1:0] reqValid = '0;
  logic [DEPTH*TW-1:0] reqThread = '0;
  logic [DEPTH-1:0] reqRowHit = '0;
  logic [DEPTH*AW-1:0] reqAge = '0;
  logic [NT-1:0] thrLimiter = '0;
  logic [NT-1:0] thrLatency = '0;
  logic [NT*IW-1:0] thrIntensity = '0;
  logic [NT*RW-1:0] thrRank = '0;
  logic loopValid = 1'b0;
  logic [NT-1:0] loopBranchHit = '0;
  logic barrier = 1'b0;
  logic intervalEnd = 1'b0;
  logic grantValid;
  logic [6:0] grantIdx;

  int errors = 0;
  int checks = 0;
  logic [31:0] cntM [NT];
  logic [31:0] snapM [NT];
  bit useLoopM = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  thrd_req_arbiter dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqThread(reqThread),
    .reqRowHit(reqRowHit), .reqAge(reqAge), .thrLimiter(thrLimiter),
    .thrLatency(thrLatency), .thrIntensity(thrIntensity), .thrRank(thrRank),
    .loopValid(loopValid), .loopBranchHit(loopBranchHit), .barrier(barrier),
    .intervalEnd(intervalEnd), .grantValid(grantValid), .grantIdx(grantIdx)
  );

  // layered ordering written from the requirements: 1 when entry a beats entry b
  function automatic bit beats(int a, int b);
    int ta = reqThread[a*TW +: TW];
    int tb = reqThread[b*TW +: TW];
    if (reqRowHit[a] != reqRowHit[b]) return reqRowHit[a];             // R2
    if (thrLimiter[ta] != thrLimiter[tb]) return thrLimiter[ta];       // R3
    if (thrLimiter[ta]) begin
      if (thrLatency[ta] != thrLatency[tb]) return thrLatency[ta];     // R4
      if (thrLatency[ta] && thrIntensity[ta*IW +: IW] != thrIntensity[tb*IW +: IW])
        return thrIntensity[ta*IW +: IW] < thrIntensity[tb*IW +: IW];
    end else if (useLoopM && snapM[ta] != snapM[tb]) begin
      return snapM[ta] < snapM[tb];                                    // R6
    end
    if (thrRank[ta*RW +: RW] != thrRank[tb*RW +: RW])                  // R5 R6 R7
      return thrRank[ta*RW +: RW] > thrRank[tb*RW +: RW];
    if (reqAge[a*AW +: AW] != reqAge[b*AW +: AW])                      // R10
      return reqAge[a*AW +: AW] > reqAge[b*AW +: AW];
    return a < b;
  endfunction

  function automatic int expWinner();
    int best = -1;
    for (int i = 0; i < DEPTH; i++)
      if (reqValid[i] && (best < 0 || beats(i, best))) best = i;
    return best;
  endfunction

  task automatic checkGrant(string req);
    int e = expWinner();
    checks++;
    if (e < 0) begin
      if (grantValid !== 1'b0) begin
        errors++;
        $display("FAIL %s: grantValid=%0b expected 0", req, grantValid);
      end
    end else if (grantValid !== 1'b1 || int'(grantIdx) != e) begin
      errors++;
      $display("FAIL %s: grantValid=%0b idx=%0d expected valid idx=%0d", req, grantValid, grantIdx, e);
    end
  endtask

  task automatic clearQ();
    reqValid = '0; reqRowHit = '0; reqAge = '0; reqThread = '0;
    thrLimiter = '0; thrLatency = '0; thrIntensity = '0; thrRank = '0;
  endtask

  task automatic putReq(int i, int t, bit hit, int age);
    reqValid[i] = 1'b1; reqThread[i*TW +: TW] = TW'(t);
    reqRowHit[i] = hit; reqAge[i*AW +: AW] = AW'(age);
  endtask

  // one clock of loop control, mirrored into the bench model
  task automatic step(logic [NT-1:0] hit, bit bar, bit cap, bit lv);
    @(negedge clk);
    loopBranchHit = hit; barrier = bar; intervalEnd = cap; loopValid = lv;
    @(posedge clk);
    for (int t = 0; t < NT; t++) begin
      if (cap) snapM[t] = cntM[t];
      if (bar) cntM[t] = '0;
      else if (hit[t]) cntM[t] = cntM[t] + 1;
    end
    if (cap) useLoopM = lv;
    @(negedge clk);
    loopBranchHit = '0; barrier = 0; intervalEnd = 0;
    #1;
  endtask

  task automatic settle();
    #1;
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int t = 0; t < NT; t++) begin cntM[t] = '0; snapM[t] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1; #1;

    // R1 reset / empty queue
    clearQ(); settle(); checkGrant("R1 empty");
    // R9 reset: all captured counts zero, loop off -> rank decides between non-limiters
    thrRank[2*RW +: RW] = 4'd1; thrRank[7*RW +: RW] = 4'd9;
    putReq(0, 2, 0, 5); putReq(1, 7, 0, 5); settle(); checkGrant("R9 reset state");

    // R2 row hit beats limiter latency thread
    clearQ(); thrLimiter[1] = 1; thrLatency[1] = 1;
    putReq(10, 1, 0, 200); putReq(20, 4, 1, 0); settle(); checkGrant("R2 row hit");
    // R3 limiter beats non-limiter with higher rank
    clearQ(); thrLimiter[3] = 1; thrRank[5*RW +: RW] = 4'hF;
    putReq(4, 5, 1, 9); putReq(9, 3, 1, 0); settle(); checkGrant("R3 limiter");
    // R4 latency over bandwidth, then lower intensity
    clearQ(); thrLimiter[6] = 1; thrLimiter[8] = 1; thrLimiter[9] = 1;
    thrLatency[8] = 1; thrLatency[9] = 1;
    thrIntensity[8*IW +: IW] = 8'd40; thrIntensity[9*IW +: IW] = 8'd12;
    thrRank[6*RW +: RW] = 4'hF;
    putReq(0, 6, 0, 0); putReq(1, 8, 0, 0); settle(); checkGrant("R4 latency class");
    putReq(2, 9, 0, 0); settle(); checkGrant("R4 intensity");
    // R5 bandwidth limiters by rank
    clearQ(); thrLimiter[10] = 1; thrLimiter[11] = 1;
    thrRank[10*RW +: RW] = 4'd3; thrRank[11*RW +: RW] = 4'd12;
    putReq(0, 10, 0, 100); putReq(5, 11, 0, 1); settle(); checkGrant("R5 rank");
    // R10 age then index
    clearQ(); putReq(30, 2, 0, 7); putReq(40, 3, 0, 9); settle(); checkGrant("R10 age");
    reqAge[40*AW +: AW] = 8'd7; settle(); checkGrant("R10 index");

    // R8 R6: thread 3 five hits, thread 5 two hits, capture with loop valid
    for (int k = 0; k < 5; k++) step(16'h0008 | (k < 2 ? 16'h0020 : 16'h0000), 0, 0, 0);
    step('0, 0, 1, 1);
    clearQ(); thrRank[5*RW +: RW] = 4'd0; thrRank[3*RW +: RW] = 4'd15;
    putReq(0, 3, 0, 50); putReq(1, 5, 0, 0); settle(); checkGrant("R8 R6 lower count");
    // R9 hold: more hits on thread 5 without capture, grant must not change
    for (int k = 0; k < 6; k++) step(16'h0020, 0, 0, 1);
    settle(); checkGrant("R9 snapshot held");
    // R7 capture with loop progress off: rank decides
    step('0, 0, 1, 0); settle(); checkGrant("R7 rank only");
    // R8 barrier wins over increment; R6 tie on count -> rank
    step(16'hFFFF, 1, 0, 1); step('0, 0, 1, 1);
    thrRank[3*RW +: RW] = 4'd2; thrRank[5*RW +: RW] = 4'd8;
    settle(); checkGrant("R8 barrier clear R6 tie rank");
    // R9 capture same cycle as barrier takes pre-clear values
    step(16'h0008, 0, 0, 1); step('0, 1, 1, 1);
    settle(); checkGrant("R9 capture with barrier");

    // random mix
    for (int n = 0; n < 400; n++) begin
      clearQ();
      for (int t = 0; t < NT; t++) begin
        thrLimiter[t] = ($urandom % 3) == 0;
        thrLatency[t] = $urandom % 2;
        thrIntensity[t*IW +: IW] = IW'($urandom % 4);
        thrRank[t*RW +: RW] = RW'($urandom % 4);
      end
      for (int i = 0; i < DEPTH; i++)
        if (($urandom % 4) == 0) putReq(i, $urandom % NT, ($urandom % 5) == 0, $urandom % 4);
      if ((n % 7) == 0) begin
        for (int i = 0; i < DEPTH; i++) reqRowHit[i] = 1'b0;
      end
      step(NT'($urandom), ($urandom % 23) == 0, ($urandom % 9) == 0, $urandom % 2);
      settle();
      checkGrant("R1 R2 R3 R4 R5 R6 R7 R10 random");
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule